// File: doc/BRIEF.md
# Transmit Descriptor Chain Engine

This block moves outgoing packets from memory to a byte stream. It follows a linked list of descriptors kept in memory. Each descriptor is three 32-bit words at consecutive word addresses. The word at offset 0 holds the buffer byte address, the word at offset 4 holds the size/status word, and the word at offset 8 holds the pointer to the next descriptor. For every descriptor that is not yet marked empty, the engine streams the packet bytes, writes the size word back with its empty flag set, and then moves on along the next pointer.

A run starts when the host writes the run-enable control bit while transmit is enabled. The run ends at the first descriptor whose size word already carries the empty flag. At that point the engine pulses an underrun strobe and drops its run-enable bit. A per-packet strobe tells a status block that one descriptor has been completed. A loopback input sends the bytes to a receive-side port instead of the line port. Memory is reached through a simple request port that holds each request until it is acknowledged.

Top module: `txd_engine`

## Requirements
- R1: After reset, `dma_en`, `mem_req`, `line_valid`, `lb_valid`, `pkt_sent` and `underrun` are all low.
- R2: A run starts only when `ctl_wr` is high with `ctl_en` = 1 while `cfg_tx_en` = 1. A control write with `cfg_tx_en` = 0, or with `ctl_en` = 0, issues no memory request.
- R3: Writes to the descriptor base force address bits 1:0 to zero. The first descriptor read of a run goes to the base with those bits cleared.
- R4: Each descriptor is read in a fixed order: buffer address at pointer+0, size word at pointer+4, next pointer at pointer+8. The data words of the packet are read after these three.
- R5: Bit 31 of the size word is the empty flag. When a fetched descriptor has it set, the engine makes no further memory request. It pulses `underrun` for one cycle and clears `dma_en`.
- R6: Bits 10:0 of the size word give the packet length in bytes. The bytes are taken from the buffer address upward. The byte at address a sits in bits 8*(a mod 4)+7 : 8*(a mod 4) of the aligned word. `tx_sop` marks the first byte and `tx_eop` marks the last.
- R7: After the last byte, the engine writes the size word back to pointer+4 with bit 31 set and all other bits unchanged.
- R8: `pkt_sent` pulses for one cycle after each write-back is acknowledged, and the next descriptor is taken from the next pointer. `pkt_sent` and `underrun` never pulse together.
- R9: A descriptor of length zero emits no bytes. It is still written back and still counted by `pkt_sent`.
- R10: `cfg_loop_en` is sampled once per descriptor. When it is 1, bytes go out on the `lb_*` handshake and `line_valid` stays low; when it is 0, the reverse holds. The two valids are never high together.
- R11: While a valid is high and its ready is low, the valid, `tx_data`, `tx_sop` and `tx_eop` hold their values.
- R12: While `mem_req` is high and `mem_ack` is low, the request, its address and its direction hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_tx_en | input | 1 | Transmit enable configuration |
| cfg_loop_en | input | 1 | Route packets to the loopback port |
| base_wr | input | 1 | Write strobe for the descriptor base |
| base_wdata | input | AW | Descriptor base value |
| ctl_wr | input | 1 | Write strobe for the run-enable bit |
| ctl_en | input | 1 | Value written to the run-enable bit |
| dma_en | output | 1 | Current run-enable bit |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | AW | Byte address (word aligned) |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Request accepted this cycle |
| mem_rdata | input | 32 | Read data, valid with `mem_ack` |
| tx_data | output | 8 | Packet byte |
| tx_sop | output | 1 | First byte of packet |
| tx_eop | output | 1 | Last byte of packet |
| line_valid | output | 1 | Byte offered to the line |
| line_ready | input | 1 | Line accepts byte |
| lb_valid | output | 1 | Byte offered to the loopback path |
| lb_ready | input | 1 | Loopback path accepts byte |
| pkt_sent | output | 1 | One descriptor completed |
| underrun | output | 1 | Run ended at an empty descriptor |

## Verification
The hardest case to reach from the ports combines three conditions at once. Buffers start at unaligned addresses, so a word refill falls in the middle of a packet. Memory acknowledges and stream ready are withheld, so requests and bytes must hold across many cycles. And the loopback choice changes from one run to the next. The stimulus builds chains with random lengths, random buffer offsets, random upper size bits and random throttling, all from a fixed seed. It also runs directed chains where the very first descriptor is empty and where one descriptor has length zero. A bench model walks a snapshot of memory to predict the full read address sequence, the write-backs and the byte stream.

// File: rtl/txd_pkg.sv
package txd_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DADDR,
        ST_DSIZE,
        ST_DNEXT,
        ST_FILL,
        ST_SEND,
        ST_WBACK
    } txd_state_e;
endpackage

// File: rtl/txd_lane.sv
module txd_lane (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        load,
    input  logic [31:0] rdata,
    input  logic [1:0]  off,
    output logic [7:0]  byte_o
);
    logic [31:0] word_d, word_q;

    always_comb begin
        word_d = word_q;
        if (load) word_d = rdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) word_q <= '0;
        else        word_q <= word_d;
    end

    assign byte_o = word_q[8*off +: 8];
endmodule

// File: rtl/txd_route.sv
module txd_route (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       emit,
    input  logic       lb_sel,
    input  logic       line_ready,
    input  logic       lb_ready,
    input  logic [7:0] byte_i,
    input  logic       sop,
    input  logic       eop,
    output logic       line_valid,
    output logic       lb_valid,
    output logic       emit_ready
);
    assign line_valid = emit & ~lb_sel;
    assign lb_valid   = emit & lb_sel;
    assign emit_ready = lb_sel ? lb_ready : line_ready;

    assert_one_path_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({line_valid, lb_valid}));

    assert_line_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        line_valid && !line_ready |=> line_valid && $stable(byte_i) && $stable(sop) && $stable(eop));

    assert_lb_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        lb_valid && !lb_ready |=> lb_valid && $stable(byte_i) && $stable(sop) && $stable(eop));
endmodule

// File: rtl/txd_ctrl.sv
module txd_ctrl
    import txd_pkg::*;
#(
    parameter int unsigned AW        = 32,
    parameter int unsigned LEN_W     = 11,
    parameter int unsigned EMPTY_BIT = 31
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_tx_en,
    input  logic          cfg_loop_en,
    input  logic          base_wr,
    input  logic [AW-1:0] base_wdata,
    input  logic          ctl_wr,
    input  logic          ctl_en,
    output logic          dma_en,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [31:0]   mem_wdata,
    input  logic          mem_ack,
    input  logic [31:0]   mem_rdata,
    output logic          word_load,
    output logic [1:0]    byte_off,
    output logic          emit,
    output logic          sop,
    output logic          eop,
    output logic          lb_sel,
    input  logic          emit_ready,
    output logic          pkt_sent,
    output logic          underrun
);
    localparam logic [AW-1:0] OFS_SIZE = AW'(4);
    localparam logic [AW-1:0] OFS_NEXT = AW'(8);
    localparam logic [31:0]   EMPTY_M  = 32'(1) << EMPTY_BIT;

    typedef struct packed {
        txd_state_e       st;
        logic [AW-1:0]    base;
        logic [AW-1:0]    ptr;
        logic [AW-1:0]    bufa;
        logic [31:0]      size;
        logic [AW-1:0]    nxt;
        logic [LEN_W-1:0] idx;
        logic             lb;
        logic             en;
        logic             sent;
        logic             unf;
    } ctl_s;

    ctl_s d, q;
    logic [LEN_W-1:0] len;
    logic [AW-1:0]    cur;
    logic             last;

    assign len  = q.size[LEN_W-1:0];
    assign cur  = q.bufa + AW'(q.idx);
    assign last = (q.idx == len - LEN_W'(1));

    always_comb begin
        d         = q;
        d.sent    = 1'b0;
        d.unf     = 1'b0;
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        word_load = 1'b0;
        if (base_wr) d.base = {base_wdata[AW-1:2], 2'b00};
        case (q.st)
            ST_IDLE: begin
                if (ctl_wr) begin
                    d.en = ctl_en;
                    if (ctl_en && cfg_tx_en) begin
                        d.ptr = q.base;
                        d.st  = ST_DADDR;
                    end
                end
            end
            ST_DADDR: begin
                mem_req  = 1'b1;
                mem_addr = q.ptr;
                if (mem_ack) begin
                    d.bufa = AW'(mem_rdata);
                    d.st   = ST_DSIZE;
                end
            end
            ST_DSIZE: begin
                mem_req  = 1'b1;
                mem_addr = q.ptr + OFS_SIZE;
                if (mem_ack) begin
                    d.size = mem_rdata;
                    d.st   = ST_DNEXT;
                end
            end
            ST_DNEXT: begin
                mem_req  = 1'b1;
                mem_addr = q.ptr + OFS_NEXT;
                if (mem_ack) begin
                    d.nxt = AW'(mem_rdata);
                    d.idx = '0;
                    d.lb  = cfg_loop_en;
                    if (q.size[EMPTY_BIT]) begin
                        d.st  = ST_IDLE;
                        d.en  = 1'b0;
                        d.unf = 1'b1;
                    end else if (len == '0) begin
                        d.st = ST_WBACK;
                    end else begin
                        d.st = ST_FILL;
                    end
                end
            end
            ST_FILL: begin
                mem_req  = 1'b1;
                mem_addr = {cur[AW-1:2], 2'b00};
                if (mem_ack) begin
                    word_load = 1'b1;
                    d.st      = ST_SEND;
                end
            end
            ST_SEND: begin
                if (emit_ready) begin
                    if (last) begin
                        d.st = ST_WBACK;
                    end else begin
                        d.idx = q.idx + LEN_W'(1);
                        if (cur[1:0] == 2'b11) d.st = ST_FILL;
                    end
                end
            end
            ST_WBACK: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = q.ptr + OFS_SIZE;
                mem_wdata = q.size | EMPTY_M;
                if (mem_ack) begin
                    d.sent = 1'b1;
                    d.ptr  = q.nxt;
                    d.st   = ST_DADDR;
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{st: ST_IDLE, default: '0};
        else        q <= d;
    end

    assign dma_en   = q.en;
    assign emit     = (q.st == ST_SEND);
    assign sop      = (q.idx == '0);
    assign eop      = last;
    assign byte_off = cur[1:0];
    assign lb_sel   = q.lb;
    assign pkt_sent = q.sent;
    assign underrun = q.unf;

    assert_req_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we));

    assert_end_drops_en_R5: assert property (@(posedge clk) disable iff (!rst_n)
        underrun |-> !dma_en);

    assert_strobe_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({pkt_sent, underrun}));

    assert_sent_after_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_sent |-> $past(mem_req && mem_we && mem_ack));
endmodule

// File: rtl/txd_engine.sv
module txd_engine #(
    parameter int unsigned AW        = 32,
    parameter int unsigned LEN_W     = 11,
    parameter int unsigned EMPTY_BIT = 31
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_tx_en,
    input  logic          cfg_loop_en,
    input  logic          base_wr,
    input  logic [AW-1:0] base_wdata,
    input  logic          ctl_wr,
    input  logic          ctl_en,
    output logic          dma_en,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [31:0]   mem_wdata,
    input  logic          mem_ack,
    input  logic [31:0]   mem_rdata,
    output logic [7:0]    tx_data,
    output logic          tx_sop,
    output logic          tx_eop,
    output logic          line_valid,
    input  logic          line_ready,
    output logic          lb_valid,
    input  logic          lb_ready,
    output logic          pkt_sent,
    output logic          underrun
);
    logic       word_load, emit, lb_sel, emit_ready;
    logic [1:0] byte_off;

    txd_ctrl #(.AW(AW), .LEN_W(LEN_W), .EMPTY_BIT(EMPTY_BIT)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_tx_en  (cfg_tx_en),
        .cfg_loop_en(cfg_loop_en),
        .base_wr    (base_wr),
        .base_wdata (base_wdata),
        .ctl_wr     (ctl_wr),
        .ctl_en     (ctl_en),
        .dma_en     (dma_en),
        .mem_req    (mem_req),
        .mem_we     (mem_we),
        .mem_addr   (mem_addr),
        .mem_wdata  (mem_wdata),
        .mem_ack    (mem_ack),
        .mem_rdata  (mem_rdata),
        .word_load  (word_load),
        .byte_off   (byte_off),
        .emit       (emit),
        .sop        (tx_sop),
        .eop        (tx_eop),
        .lb_sel     (lb_sel),
        .emit_ready (emit_ready),
        .pkt_sent   (pkt_sent),
        .underrun   (underrun)
    );

    txd_lane u_lane (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (word_load),
        .rdata (mem_rdata),
        .off   (byte_off),
        .byte_o(tx_data)
    );

    txd_route u_route (
        .clk       (clk),
        .rst_n     (rst_n),
        .emit      (emit),
        .lb_sel    (lb_sel),
        .line_ready(line_ready),
        .lb_ready  (lb_ready),
        .byte_i    (tx_data),
        .sop       (tx_sop),
        .eop       (tx_eop),
        .line_valid(line_valid),
        .lb_valid  (lb_valid),
        .emit_ready(emit_ready)
    );
endmodule

// File: tb/test_txd_engine.sv
module test_txd_engine;
    localparam int AW = 32;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic          rst_n = 1'b0;
    logic          cfg_tx_en = 1'b1, cfg_loop_en = 1'b0;
    logic          base_wr = 1'b0, ctl_wr = 1'b0, ctl_en = 1'b0;
    logic [AW-1:0] base_wdata = '0;
    logic          dma_en, mem_req, mem_we, mem_ack = 1'b0;
    logic [AW-1:0] mem_addr;
    logic [31:0]   mem_wdata, mem_rdata = '0;
    logic [7:0]    tx_data;
    logic          tx_sop, tx_eop, line_valid, lb_valid;
    logic          line_ready = 1'b0, lb_ready = 1'b0;
    logic          pkt_sent, underrun;

    txd_engine #(.AW(AW)) i_txd_engine (
        .clk(clk), .rst_n(rst_n), .cfg_tx_en(cfg_tx_en), .cfg_loop_en(cfg_loop_en),
        .base_wr(base_wr), .base_wdata(base_wdata), .ctl_wr(ctl_wr), .ctl_en(ctl_en),
        .dma_en(dma_en), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .tx_data(tx_data), .tx_sop(tx_sop), .tx_eop(tx_eop),
        .line_valid(line_valid), .line_ready(line_ready),
        .lb_valid(lb_valid), .lb_ready(lb_ready),
        .pkt_sent(pkt_sent), .underrun(underrun)
    );

    logic [31:0] mem [0:4095];
    int checks = 0, errors = 0;
    bit throttle = 1'b0, done = 1'b0;

    logic [31:0] rd_log [0:511];
    logic [31:0] wa_log [0:63];
    logic [31:0] wd_log [0:63];
    logic [9:0]  ln_log [0:1023];
    logic [9:0]  lb_log [0:1023];
    int rd_n, wr_n, ln_n, lb_n, sent_n, unf_n, hold_bad, req_bad;

    logic [31:0] exp_rd [0:511];
    logic [31:0] exp_wa [0:63];
    logic [31:0] exp_wd [0:63];
    logic [9:0]  exp_b  [0:1023];
    int exp_rn, exp_wn, exp_bn, exp_pk;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] mbyte(input logic [31:0] a);
        logic [31:0] w;
        w = mem[a[13:2]];
        return w[8*a[1:0] +: 8];
    endfunction

    // Reference walk over a snapshot of memory before the run starts
    task automatic model(input logic [31:0] base);
        logic [31:0] p, a, s, n, ba;
        int len;
        exp_rn = 0; exp_wn = 0; exp_bn = 0; exp_pk = 0;
        p = base & ~32'h3;
        for (int g = 0; g < 16; g++) begin
            a = mem[p[13:2]];
            s = mem[p[13:2] + 12'd1];
            n = mem[p[13:2] + 12'd2];
            exp_rd[exp_rn] = p; exp_rd[exp_rn+1] = p + 4; exp_rd[exp_rn+2] = p + 8;
            exp_rn += 3;
            if (s[31]) break;
            len = int'(s[10:0]);
            for (int i = 0; i < len; i++) begin
                ba = a + 32'(i);
                if (i == 0 || ba[1:0] == 2'b00) begin
                    exp_rd[exp_rn] = {ba[31:2], 2'b00};
                    exp_rn++;
                end
                exp_b[exp_bn] = {(i == 0), (i == len - 1), mbyte(ba)};
                exp_bn++;
            end
            exp_wa[exp_wn] = p + 4;
            exp_wd[exp_wn] = s | 32'h8000_0000;
            exp_wn++;
            exp_pk++;
            p = n;
        end
    endtask

    task automatic build(input int nd, input int zero_at, input bit first_empty,
                         output logic [31:0] base);
        logic [31:0] dp, s, a;
        int len;
        for (int k = 0; k <= nd; k++) begin
            dp = 32'h100 + 32'(k) * 32;
            a  = 32'h1000 + 32'(k) * 32'h100 + 32'($urandom % 4);
            for (int w = 0; w < 64; w++) mem[12'h400 + 12'(k) * 12'h40 + 12'(w)] = $urandom;
            if (k == nd || (first_empty && k == 0)) begin
                s = $urandom | 32'h8000_0000;
            end else begin
                len = (k == zero_at) ? 0 : 1 + int'($urandom % 40);
                s = {1'b0, 20'($urandom), 11'(len)};
            end
            mem[dp[13:2]]         = a;
            mem[dp[13:2] + 12'd1] = s;
            mem[dp[13:2] + 12'd2] = (k == nd) ? $urandom : dp + 32;
        end
        base = 32'h100 | 32'($urandom % 4);
    endtask

    task automatic clear_logs();
        rd_n = 0; wr_n = 0; ln_n = 0; lb_n = 0; sent_n = 0; unf_n = 0;
        hold_bad = 0; req_bad = 0;
    endtask

    // Memory responder, stream sink and monitor
    initial begin
        bit pend_v, pend_r;
        logic [9:0] pend_b;
        logic [31:0] pend_a;
        logic pend_we;
        bit ack_v;
        pend_v = 0; pend_r = 0; pend_b = '0; pend_a = '0; pend_we = 0;
        forever begin
            @(negedge clk);
            #1;
            if (rst_n) begin
                if (pend_r && !(mem_req && mem_addr == pend_a && mem_we == pend_we)) req_bad++;
                if (pend_v && !((line_valid || lb_valid) && {tx_sop, tx_eop, tx_data} == pend_b))
                    hold_bad++;
            end
            ack_v = throttle ? ($urandom % 3 != 0) : 1'b1;
            mem_ack = mem_req && ack_v;
            if (mem_req && ack_v) begin
                if (mem_we) begin
                    mem[mem_addr[13:2]] = mem_wdata;
                    if (wr_n < 64) begin wa_log[wr_n] = mem_addr; wd_log[wr_n] = mem_wdata; end
                    wr_n++;
                end else begin
                    mem_rdata = mem[mem_addr[13:2]];
                    if (rd_n < 512) rd_log[rd_n] = mem_addr;
                    rd_n++;
                end
            end
            line_ready = throttle ? ($urandom % 2 == 0) : 1'b1;
            lb_ready   = throttle ? ($urandom % 2 == 0) : 1'b1;
            if (line_valid && line_ready) begin
                if (ln_n < 1024) ln_log[ln_n] = {tx_sop, tx_eop, tx_data};
                ln_n++;
            end
            if (lb_valid && lb_ready) begin
                if (lb_n < 1024) lb_log[lb_n] = {tx_sop, tx_eop, tx_data};
                lb_n++;
            end
            pend_r = mem_req && !mem_ack;
            pend_a = mem_addr; pend_we = mem_we;
            pend_v = (line_valid && !line_ready) || (lb_valid && !lb_ready);
            pend_b = {tx_sop, tx_eop, tx_data};
            if (pkt_sent) sent_n++;
            if (underrun) unf_n++;
        end
    end

    task automatic host_start(input logic [31:0] base, input bit en);
        @(negedge clk); base_wr = 1'b1; base_wdata = base;
        @(negedge clk); base_wr = 1'b0; ctl_wr = 1'b1; ctl_en = en;
        @(negedge clk); ctl_wr = 1'b0;
    endtask

    task automatic run_chain(input logic [31:0] base, input bit lb, input string tag);
        int t, bad, got_n, first_bad;
        logic [31:0] a0, e0;
        model(base);
        clear_logs();
        cfg_loop_en = lb;
        host_start(base, 1'b1);
        t = 0;
        while (unf_n == 0 && t < 20000) begin @(negedge clk); t++; end
        repeat (20) @(negedge clk);
        check(unf_n == 1, "R5", {tag, " underrun pulses"}, unf_n, 1);
        check(dma_en == 1'b0, "R5", {tag, " dma_en after end"}, dma_en, 0);
        bad = 0; first_bad = -1;
        for (int i = 0; i < exp_rn && i < rd_n; i++)
            if (rd_log[i] != exp_rd[i]) begin bad++; if (first_bad < 0) first_bad = i; end
        a0 = (first_bad >= 0) ? rd_log[first_bad] : 32'(rd_n);
        e0 = (first_bad >= 0) ? exp_rd[first_bad] : 32'(exp_rn);
        check(rd_n == exp_rn && bad == 0, "R4", {tag, " read sequence"}, a0, e0);
        check(rd_n > 0 && rd_log[0] == (base & ~32'h3), "R3", {tag, " first read"},
              rd_log[0], base & ~32'h3);
        bad = 0;
        for (int i = 0; i < exp_wn && i < wr_n; i++)
            if (wa_log[i] != exp_wa[i] || wd_log[i] != exp_wd[i]) bad++;
        check(wr_n == exp_wn && bad == 0, "R7", {tag, " write-backs"}, wr_n, exp_wn);
        check(sent_n == exp_pk, "R8", {tag, " pkt_sent pulses"}, sent_n, exp_pk);
        got_n = lb ? lb_n : ln_n;
        bad = 0;
        for (int i = 0; i < exp_bn && i < got_n; i++)
            if ((lb ? lb_log[i] : ln_log[i]) != exp_b[i]) bad++;
        check(got_n == exp_bn && bad == 0, "R6", {tag, " byte stream"}, got_n, exp_bn);
        check((lb ? ln_n : lb_n) == 0, "R10", {tag, " unused port silent"}, lb ? ln_n : lb_n, 0);
        check(hold_bad == 0, "R11", {tag, " stream hold"}, hold_bad, 0);
        check(req_bad == 0, "R12", {tag, " request hold"}, req_bad, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] base;
        void'($urandom(32'd20250611));
        for (int i = 0; i < 4096; i++) mem[i] = '0;
        clear_logs();
        repeat (3) @(negedge clk);
        check(!dma_en && !mem_req && !line_valid && !lb_valid && !pkt_sent && !underrun,
              "R1", "state in reset", {dma_en, mem_req, line_valid, lb_valid, pkt_sent, underrun}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(!dma_en && !mem_req && !line_valid && !lb_valid,
              "R1", "state after reset", {dma_en, mem_req, line_valid, lb_valid}, 0);

        // R2: transmit disabled, then enable bit written as zero
        build(2, -1, 1'b0, base);
        cfg_tx_en = 1'b0;
        clear_logs();
        host_start(base, 1'b1);
        repeat (30) @(negedge clk);
        check(rd_n == 0 && unf_n == 0, "R2", "no run with tx disabled", rd_n, 0);
        cfg_tx_en = 1'b1;
        clear_logs();
        host_start(base, 1'b0);
        repeat (30) @(negedge clk);
        check(rd_n == 0 && dma_en == 1'b0, "R2", "no run with enable zero", rd_n, 0);

        // R5: first descriptor already empty
        build(1, -1, 1'b1, base);
        run_chain(base, 1'b0, "first-empty");
        check(ln_n == 0 && rd_n == 3, "R5", "empty head emits nothing", ln_n + rd_n, 3);

        // R9: zero-length descriptor in the middle of a chain
        build(3, 1, 1'b0, base);
        run_chain(base, 1'b0, "zero-length");
        check(sent_n == 3 && ln_n == exp_bn, "R9", "zero-length counted", sent_n, 3);

        // Random chains with throttling and loopback
        throttle = 1'b1;
        for (int r = 0; r < 8; r++) begin
            build(1 + int'($urandom % 5), ($urandom % 3 == 0) ? 0 : -1, 1'b0, base);
            run_chain(base, 1'($urandom % 2), $sformatf("random%0d", r));
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule